// File: doc/BRIEF.md
# Periodic Down-Counting Timer

A register-mapped timer channel built around a down-counter. Software writes a start count, picks a prescaler ratio, a counter width and a counting mode, then sets the run bit. Every prescaled tick takes one off the count. When the count steps from one to zero the block raises a raw interrupt flag. The counter then either restarts from a stored reload value (periodic), rolls to the all-ones value of its width (free-running), or parks at zero (one-shot).

A second reload register lets software change the period of a running timer. The new value is used at the next expiry and leaves the current count alone. The flag is cleared by any write to the acknowledge word. The interrupt line is the flag gated by the interrupt-enable bit. All accesses complete in a single cycle: writes take effect at the clock edge, and reads are combinational from the address.

Top module: `tick_timer`

## Requirements
- R1: After reset the control word, the count, the reload value and the raw flag are all zero, and `irq` is low.
- R2: The control word at byte offset 0x08 is 8 bits wide and reads back exactly what was last written, bit 4 included (bit 4 has no function). Its fields are: bit 7 run, bit 6 periodic, bit 5 interrupt enable, bits 3:2 prescaler code, bit 1 wide counter, bit 0 one-shot.
- R3: A write to offset 0x00 sets both the count and the reload value. Offsets 0x00 and 0x18 read the reload value. Offset 0x04 reads the count, limited to its low 16 bits while bit 1 is clear.
- R4: A write to offset 0x18 changes only the reload value. The running count is untouched, and the new value first takes effect at the next expiry.
- R5: While running, each prescaled tick decrements the count. A tick that brings the count from 1 to 0 is an expiry. In periodic mode the counter takes the reload value on that same tick, so a reload of N gives a period of N ticks.
- R6: In free-running mode (bit 6 clear) an expiry sets the count to 0xFFFF when bit 1 is clear and to 0xFFFFFFFF when bit 1 is set. While bit 1 is clear the upper 16 bits of the read count are zero.
- R7: With bit 0 set, an expiry leaves the count at 0, and the count then stays at 0 while the mode holds.
- R8: Prescaler code 00 gives a tick on every enabled cycle, code 01 on every 16th, and code 10 (and 11) on every 256th.
- R9: Setting the run bit while it is clear restarts the prescaler, so the first tick after a start comes a full prescaled period later.
- R10: While the run bit is clear, neither the count nor the prescaler moves, and a pending flag stays set.
- R11: An expiry sets the raw flag (bit 0 at offset 0x10). A write of any data to offset 0x0C clears it, and an expiry in the same cycle wins over the clear. Bit 0 at offset 0x14 and the `irq` output are the raw flag ANDed with the interrupt-enable bit.
- R12: A write to offset 0x00 in a cycle that also carries a tick loads the written value, and the tick is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sel | input | 1 | Register access strobe |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W (5) | Byte address; bits 1:0 must be zero |
| wdata | input | DATA_W (32) | Write data |
| rdata | output | DATA_W (32) | Read data for the addressed word |
| irq | output | 1 | Level interrupt, raw flag AND interrupt enable |

## Verification
The assertions assume that each access is a single-cycle strobe to one word-aligned offset. They also assume that the inputs hold known values from the first clock after reset, so a load, a reload write and a control write never coincide. The stimulus keeps to this. Every access is driven on the falling edge, lasts one cycle and uses one of the seven defined word offsets. Idle cycles drop the strobe, and runs are stopped by a control write before the next setup.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

   // Word index taken from address bits 4:2
   typedef enum logic [2:0] {
      WIX_LOAD  = 3'd0,
      WIX_COUNT = 3'd1,
      WIX_CTRL  = 3'd2,
      WIX_ACK   = 3'd3,
      WIX_RAW   = 3'd4,
      WIX_MSK   = 3'd5,
      WIX_BGLD  = 3'd6
   } word_ix_e;

   // Control word, bit 7 down to bit 0
   typedef struct packed {
      logic       run;
      logic       periodic;
      logic       ie;
      logic       spare;
      logic [1:0] psc;
      logic       wide;
      logic       oneshot;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tt_prescaler.sv
module tt_prescaler #(
   parameter int STEP  = 4,
   parameter int CODES = 3
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       run,
   input  logic       restart,
   input  logic [1:0] code,
   output logic       tick
);
   localparam int PW = STEP * (CODES - 1);

   initial begin : param_chk
      if (CODES < 1 || CODES > 4) $fatal(1, "tt_prescaler: CODES out of range");
      if (PW > 32) $fatal(1, "tt_prescaler: divider too wide");
   end

   generate
      if (PW == 0) begin : g_bypass
         logic unused_ok;
         assign unused_ok = restart ^ (^code) ^ clk ^ rst_n;
         assign tick = run;
      end else begin : g_div
         logic [PW-1:0] pcnt_q;
         logic [PW-1:0] lim;
         int            sh;

         always_comb begin
            sh  = STEP * ((int'(code) > CODES - 1) ? (CODES - 1) : int'(code));
            lim = PW'((64'd1 << sh) - 64'd1);
         end

         assign tick = run && (pcnt_q >= lim);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pcnt_q <= '0;
            else if (restart) pcnt_q <= '0;
            else if (run)     pcnt_q <= tick ? '0 : pcnt_q + 1'b1;
         end
      end
   endgenerate

endmodule

// File: rtl/tt_counter.sv
module tt_counter #(
   parameter int DATA_W  = 32,
   parameter int SHORT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              wide,
   input  logic              periodic,
   input  logic              oneshot,
   input  logic              ld_wr,
   input  logic              bg_wr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] value,
   output logic [DATA_W-1:0] reload,
   output logic              expire
);
   logic [DATA_W-1:0] cnt_q, rel_q, span, cur, dec;
   logic              hold, at_one;

   generate
      if (SHORT_W < DATA_W) begin : g_two_sizes
         assign span = wide ? {DATA_W{1'b1}}
                            : {{(DATA_W-SHORT_W){1'b0}}, {SHORT_W{1'b1}}};
      end else begin : g_one_size
         logic unused_ok;
         assign unused_ok = wide;
         assign span = {DATA_W{1'b1}};
      end
   endgenerate

   assign cur    = cnt_q & span;
   assign dec    = (cur - 1'b1) & span;
   assign hold   = oneshot && (cur == '0);
   assign at_one = (cur == DATA_W'(1));
   assign expire = tick && !ld_wr && !hold && at_one;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (ld_wr) begin
         cnt_q <= wdata;
      end else if (tick && !hold) begin
         if (at_one) begin
            if (oneshot)       cnt_q <= '0;
            else if (periodic) cnt_q <= rel_q & span;
            else               cnt_q <= span;
         end else begin
            cnt_q <= dec;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               rel_q <= '0;
      else if (ld_wr || bg_wr)  rel_q <= wdata;
   end

   assign value  = cur;
   assign reload = rel_q;

endmodule

// File: rtl/tt_irq.sv
module tt_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic ie,
   output logic raw,
   output logic irq
);
   logic raw_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   raw_q <= 1'b0;
      else if (set) raw_q <= 1'b1;
      else if (clr) raw_q <= 1'b0;
   end

   assign raw = raw_q;
   assign irq = raw_q & ie;

endmodule

// File: rtl/tick_timer.sv
module tick_timer
   import tick_timer_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SHORT_W   = 16,
   parameter int ADDR_W    = 5,
   parameter int PSC_STEP  = 4,
   parameter int PSC_CODES = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel,
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   output logic              irq
);
   initial begin : param_chk
      if (DATA_W < CTRL_W)   $fatal(1, "tick_timer: DATA_W below control width");
      if (ADDR_W < 5)        $fatal(1, "tick_timer: ADDR_W too small for the map");
      if (SHORT_W < 1 || SHORT_W > DATA_W) $fatal(1, "tick_timer: bad SHORT_W");
   end

   ctrl_t             ctl_q;
   word_ix_e          wix;
   logic              in_win, wr_hit;
   logic              ld_wr, bg_wr, ack_wr, ctl_wr, restart;
   logic              pre_tick, cnt_expire, raw_q;
   logic [DATA_W-1:0] cnt_val, rel_val;

   assign in_win = (addr[1:0] == 2'b00) && ((addr >> 5) == '0);
   assign wix    = word_ix_e'(addr[4:2]);
   assign wr_hit = sel && wr && in_win;
   assign ld_wr  = wr_hit && (wix == WIX_LOAD);
   assign bg_wr  = wr_hit && (wix == WIX_BGLD);
   assign ack_wr = wr_hit && (wix == WIX_ACK);
   assign ctl_wr = wr_hit && (wix == WIX_CTRL);
   assign restart = ctl_wr && wdata[7] && !ctl_q.run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      ctl_q <= '0;
      else if (ctl_wr) ctl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
   end

   tt_prescaler #(.STEP(PSC_STEP), .CODES(PSC_CODES)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(ctl_q.run), .restart(restart),
      .code(ctl_q.psc), .tick(pre_tick)
   );

   tt_counter #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .tick(pre_tick), .wide(ctl_q.wide),
      .periodic(ctl_q.periodic), .oneshot(ctl_q.oneshot),
      .ld_wr(ld_wr), .bg_wr(bg_wr), .wdata(wdata),
      .value(cnt_val), .reload(rel_val), .expire(cnt_expire)
   );

   tt_irq u_irq (
      .clk(clk), .rst_n(rst_n), .set(cnt_expire), .clr(ack_wr),
      .ie(ctl_q.ie), .raw(raw_q), .irq(irq)
   );

   always_comb begin
      rdata = '0;
      if (sel && in_win) begin
         case (wix)
            WIX_LOAD, WIX_BGLD: rdata = rel_val;
            WIX_COUNT:          rdata = cnt_val;
            WIX_CTRL:           rdata = DATA_W'(ctl_q);
            WIX_RAW:            rdata = DATA_W'(raw_q);
            WIX_MSK:            rdata = DATA_W'(irq);
            default:            rdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
   parameter int DATA_W  = 32,
   parameter int SHORT_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [7:0]        ctl,
   input logic [DATA_W-1:0] value,
   input logic [DATA_W-1:0] wdata,
   input logic              raw,
   input logic              tick,
   input logic              expire,
   input logic              ld_wr,
   input logic              bg_wr,
   input logic              ack_wr,
   input logic              ctl_wr
);
   localparam logic [DATA_W-1:0] SHORT_MASK =
      (SHORT_W >= DATA_W) ? {DATA_W{1'b1}} : DATA_W'((64'd1 << SHORT_W) - 64'd1);

   // R2
   ctl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> ctl == $past(wdata[7:0]));

   // R3
   load_now_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ld_wr |=> value == ($past(wdata) & ($past(ctl[1]) ? {DATA_W{1'b1}} : SHORT_MASK)));

   // R4
   bg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bg_wr && !tick |=> $stable(value));

   // R6
   short_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[1] |-> (value & ~SHORT_MASK) == '0);

   // R8
   tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |-> ctl[7]);

   // R10
   freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl[7] && !ld_wr |=> $stable(value));

   // R11
   raw_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> raw);

   // R11
   raw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack_wr && !expire |=> !raw);

   // R11
   irq_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ctl[5] && raw);

endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq(irq), .ctl(ctl_q), .value(cnt_val),
   .wdata(wdata), .raw(raw_q), .tick(pre_tick), .expire(cnt_expire),
   .ld_wr(ld_wr), .bg_wr(bg_wr), .ack_wr(ack_wr), .ctl_wr(ctl_wr)
);

// File: tb/tick_timer_test.sv
`timescale 1ns/1ps
module tick_timer_test;
   localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                          A_ACK = 5'h0C, A_RAW = 5'h10, A_MSK = 5'h14,
                          A_BGLD = 5'h18;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        wr = 1'b0;
   logic [4:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   typedef struct {
      bit          is_irq;
      logic [31:0] exp;
      string       req;
   } item_t;

   item_t sb[$];

   always #10 clk = ~clk;

   tick_timer uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr),
      .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
   );

   task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
   endtask

   task automatic rd_chk(input logic [4:0] a, input logic [31:0] e, input string req);
      item_t it;
      @(negedge clk);
      sel = 1'b1; wr = 1'b0; addr = a; wdata = '0;
      it.is_irq = 1'b0; it.exp = e; it.req = req;
      sb.push_back(it);
   endtask

   task automatic irq_chk(input bit e, input string req);
      item_t it;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
      it.is_irq = 1'b1; it.exp = {31'b0, e}; it.req = req;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) begin
         @(negedge clk);
         sel = 1'b0; wr = 1'b0;
      end
   endtask

   // Monitor: compares each queued expectation in the cycle it was issued
   initial begin
      forever begin
         @(negedge clk);
         #2;
         if (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            act = it.is_irq ? {31'b0, irq} : rdata;
            checks++;
            if (act !== it.exp) begin
               errors++;
               $display("FAIL %s actual=%h expected=%h", it.req, act, it.exp);
            end
         end
      end
   end

   initial begin
      #(20 * 20000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd_chk(A_CTRL, 32'h0, "R1 control");
      rd_chk(A_CNT,  32'h0, "R1 count");
      rd_chk(A_RAW,  32'h0, "R1 raw");
      rd_chk(A_MSK,  32'h0, "R1 masked");
      irq_chk(1'b0, "R1 irq");

      // R2 control readback with spare bit
      wr_reg(A_CTRL, 32'h13);
      rd_chk(A_CTRL, 32'h13, "R2 control 0x13");
      wr_reg(A_CTRL, 32'h10);
      rd_chk(A_CTRL, 32'h10, "R2 control 0x10");

      // R3 load, short view, reload readback
      wr_reg(A_LOAD, 32'h0001_2345);
      rd_chk(A_CNT,  32'h0000_2345, "R3 short count");
      rd_chk(A_LOAD, 32'h0001_2345, "R3 reload read");
      wr_reg(A_LOAD, 32'd5);
      rd_chk(A_CNT, 32'd5, "R3 count after load");
      idle(3);
      rd_chk(A_CNT, 32'd5, "R10 frozen while stopped");

      // R5 periodic, div 1, interrupt enabled
      wr_reg(A_CTRL, 32'hF0);
      rd_chk(A_CNT, 32'd5, "R5 c1");
      rd_chk(A_CNT, 32'd4, "R5 c2");
      rd_chk(A_CNT, 32'd3, "R5 c3");
      rd_chk(A_CNT, 32'd2, "R5 c4");
      rd_chk(A_CNT, 32'd1, "R5 c5");
      rd_chk(A_CNT, 32'd5, "R5 reload at expiry");
      rd_chk(A_RAW, 32'd1, "R11 raw set");
      rd_chk(A_MSK, 32'd1, "R11 masked set");
      irq_chk(1'b1, "R11 irq high");

      // R10 pending flag held while stopped, R11 clear by write
      wr_reg(A_CTRL, 32'h10);
      rd_chk(A_RAW, 32'd1, "R10 flag held");
      idle(2);
      rd_chk(A_RAW, 32'd1, "R10 flag still held");
      wr_reg(A_ACK, 32'h0);
      rd_chk(A_RAW, 32'd0, "R11 cleared");
      irq_chk(1'b0, "R11 irq low");

      // R4 background reload
      wr_reg(A_LOAD, 32'd4);
      wr_reg(A_BGLD, 32'd2);
      rd_chk(A_CNT,  32'd4, "R4 count untouched");
      rd_chk(A_BGLD, 32'd2, "R4 reload read");
      wr_reg(A_CTRL, 32'hD0);
      rd_chk(A_CNT, 32'd4, "R4 c1");
      rd_chk(A_CNT, 32'd3, "R4 c2");
      rd_chk(A_CNT, 32'd2, "R4 c3");
      rd_chk(A_CNT, 32'd1, "R4 c4");
      rd_chk(A_CNT, 32'd2, "R4 new period");
      rd_chk(A_CNT, 32'd1, "R4 c6");
      rd_chk(A_CNT, 32'd2, "R4 c7");
      rd_chk(A_RAW, 32'd1, "R11 raw without enable");
      rd_chk(A_MSK, 32'd0, "R11 masked gated");
      irq_chk(1'b0, "R11 irq gated");

      // R6 free-running wrap, short
      wr_reg(A_CTRL, 32'h10);
      wr_reg(A_ACK, 32'hFFFF_FFFF);
      wr_reg(A_LOAD, 32'd2);
      wr_reg(A_CTRL, 32'h90);
      rd_chk(A_CNT, 32'd2, "R6 c1");
      rd_chk(A_CNT, 32'd1, "R6 c2");
      rd_chk(A_CNT, 32'h0000_FFFF, "R6 short wrap");
      rd_chk(A_CNT, 32'h0000_FFFE, "R6 after wrap");

      // R6 free-running wrap, wide; R12 load over tick
      wr_reg(A_CTRL, 32'h12);
      wr_reg(A_LOAD, 32'd1);
      wr_reg(A_CTRL, 32'h92);
      rd_chk(A_CNT, 32'd1, "R6 wide c1");
      rd_chk(A_CNT, 32'hFFFF_FFFF, "R6 wide wrap");
      wr_reg(A_LOAD, 32'd7);
      rd_chk(A_CNT, 32'd7, "R12 load wins");
      rd_chk(A_CNT, 32'd6, "R12 next tick");

      // R7 one-shot
      wr_reg(A_CTRL, 32'h10);
      wr_reg(A_ACK, 32'h0);
      wr_reg(A_LOAD, 32'd2);
      wr_reg(A_CTRL, 32'hD1);
      rd_chk(A_CNT, 32'd2, "R7 c1");
      rd_chk(A_CNT, 32'd1, "R7 c2");
      rd_chk(A_CNT, 32'd0, "R7 stops at zero");
      rd_chk(A_CNT, 32'd0, "R7 stays at zero");
      rd_chk(A_RAW, 32'd1, "R7 flag set");

      // R8 divide by 16
      wr_reg(A_CTRL, 32'h10);
      wr_reg(A_LOAD, 32'd3);
      wr_reg(A_CTRL, 32'h94);
      rd_chk(A_CNT, 32'd3, "R8 div16 c1");
      idle(14);
      rd_chk(A_CNT, 32'd3, "R8 div16 c16");
      rd_chk(A_CNT, 32'd2, "R8 div16 c17");

      // R9 restart of prescaler on start
      wr_reg(A_CTRL, 32'h14);
      wr_reg(A_CTRL, 32'h94);
      rd_chk(A_CNT, 32'd2, "R9 d1");
      idle(14);
      rd_chk(A_CNT, 32'd2, "R9 d16 no early tick");
      rd_chk(A_CNT, 32'd1, "R9 d17 tick");

      // R8 divide by 256
      wr_reg(A_CTRL, 32'h10);
      wr_reg(A_LOAD, 32'd1);
      wr_reg(A_CTRL, 32'h98);
      rd_chk(A_CNT, 32'd1, "R8 div256 c1");
      idle(254);
      rd_chk(A_CNT, 32'd1, "R8 div256 c256");
      rd_chk(A_CNT, 32'h0000_FFFF, "R8 div256 c257");

      idle(3);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule